// File: doc/BRIEF.md
# Memory Access Unit with Atomic Read-Modify-Write

This block carries out the data-memory instructions of a 32-bit RISC pipeline. It accepts one already-decoded request at a time: a two-bit format code, the six-bit operation code, the destination register number, both base operand values, an immediate-select flag, a 13-bit immediate and the register values to be stored. It forms the effective address, checks alignment, and runs one or two word accesses on a synchronous, byte-enabled memory port. Load results go back to the register file as a writeback beat covering one register or an even/odd pair.

Requests enter on a valid/ready pair. `in_ready` is high only while the unit is idle, so the unit holds exactly one operation. A request is taken on a rising edge where both `in_valid` and `in_ready` are high. Writeback leaves on a valid/ready pair. `wb_valid` stays high with steady data until `wb_ready` is seen high on a rising edge, and no new request is taken before that. The memory port has no stall. A read issued on one edge returns `mem_rdata` for the following cycle. A write takes effect on the edge where it is issued.

The two atomic operations are done as a locked read followed at once by a write to the same word. These are the byte test-and-set and the word exchange. Misaligned requests are refused with a one-cycle exception pulse.

Top module: `mem_access_unit`

## Requirements
- R1: The effective address is `in_rs1` plus `in_rs2` when `in_use_imm` is 0, or plus `in_simm` sign-extended to 32 bits when `in_use_imm` is 1 (the unused operand has no effect).
- R2: Operations are decoded only when `in_fmt` is 2'b11. The `in_op3` codes are: 0x00 word load, 0x01 unsigned byte load, 0x02 unsigned halfword load, 0x03 doubleword load, 0x04 word store, 0x05 byte store, 0x06 halfword store, 0x07 doubleword store, 0x09 signed byte load, 0x0A signed halfword load, 0x0D byte test-and-set, 0x0F word swap. Any other code, or any other format, is accepted and has no effect: no memory access, no writeback, no exception, and `in_ready` is high again one edge later.
- R3: Halfword accesses need the address aligned to 2. Word accesses and swap need it aligned to 4. Doubleword accesses need it aligned to 8. A misaligned request raises `exc_misalign` for exactly the one cycle after acceptance and makes no memory access and no writeback.
- R4: Memory is big-endian. Byte offset 0 of a word is bits 31:24 and offset 3 is bits 7:0. Halfword offset 0 is bits 31:16. `mem_be[3]` enables bits 31:24. `mem_addr` always carries a word address with bits 1:0 zero.
- R5: Signed byte and halfword loads sign-extend to 32 bits. Unsigned byte and halfword loads zero-extend.
- R6: Byte and halfword stores write only the addressed lanes from the low bits of `in_st_data`, leaving the other bytes of the word unchanged. Word stores write `in_st_data`.
- R7: Doubleword accesses ignore bit 0 of `in_rd`. A doubleword load returns the word at the address in `wb_data` for the even register and the word at address+4 in `wb_data2` for the odd register, with `wb_pair` high. A doubleword store writes `in_st_data` at the address and `in_st_data2` at address+4.
- R8: The byte test-and-set returns the old addressed byte zero-extended and leaves 0xFF in that byte.
- R9: Swap returns the old addressed word and leaves `in_st_data` in that word.
- R10: For the atomics, `mem_lock` is high on both the read cycle and the write cycle. The write to the same word follows the read directly, and `in_ready` stays low until the result has been consumed.
- R11: `wb_valid` rises 3 rising edges after acceptance for single loads and atomics, and 4 for doubleword loads. After a store, `in_ready` is high again 2 edges after acceptance, or 3 for a doubleword store.
- R12: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_rd`, `wb_data`, `wb_data2` and `wb_pair` hold, and no request is accepted.
- R13: After reset, `in_ready` is high and `wb_valid`, `mem_req`, `mem_lock` and `exc_misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle, request can be taken |
| in_fmt | input | 2 | Instruction format code |
| in_op3 | input | 6 | Operation code |
| in_rd | input | 5 | Destination/source register number |
| in_rs1 | input | 32 | Base operand |
| in_rs2 | input | 32 | Register offset operand |
| in_use_imm | input | 1 | Select immediate offset |
| in_simm | input | 13 | Signed immediate offset |
| in_st_data | input | 32 | Value of register rd |
| in_st_data2 | input | 32 | Value of register rd+1 |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Atomic sequence in progress |
| mem_addr | output | 32 | Word address |
| mem_be | output | 4 | Byte enables (bit 3 = bits 31:24) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| wb_valid | output | 1 | Writeback beat offered |
| wb_ready | input | 1 | Register file takes the beat |
| wb_rd | output | 5 | Register to write (even for pairs) |
| wb_data | output | 32 | Value for wb_rd |
| wb_data2 | output | 32 | Value for wb_rd+1 |
| wb_pair | output | 1 | Both registers are written |
| exc_misalign | output | 1 | Misalignment exception pulse |

## Verification
Latency is counted in rising edges from the edge on which the request is taken. The exception is due after 1 edge. Writeback is due after 3 edges, or 4 for a doubleword load. `in_ready` returns 2 or 3 edges after a store, and 1 edge after a refused or ignored request. The atomic read and write cycles fall after edges 1 and 2. The bench drives and samples on falling edges. After each acceptance it steps through six falling edges in turn and records the first one at which each output appears. It then compares those edge numbers with the values above, and compares the writeback values and the whole memory image with a bench-side big-endian model.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_LD, K_LDD, K_ST, K_STD, K_TAS, K_SWAP
  } kind_e;

  // encoded as log2 of the access size in bytes
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} size_e;

  typedef struct packed {
    kind_e kind;
    size_e size;
    logic  sign;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE0, ST_ISSUE1, ST_CAPT, ST_WB
  } state_e;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic [1:0]      fmt,
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);
  localparam logic [1:0] MEM_FMT = 2'b11;

  always_comb begin
    dec = '{kind: K_NONE, size: SZ_W, sign: 1'b0};
    if (fmt == MEM_FMT) begin
      case (op)
        OP_W'('h00): dec = '{kind: K_LD,   size: SZ_W, sign: 1'b0};
        OP_W'('h01): dec = '{kind: K_LD,   size: SZ_B, sign: 1'b0};
        OP_W'('h02): dec = '{kind: K_LD,   size: SZ_H, sign: 1'b0};
        OP_W'('h03): dec = '{kind: K_LDD,  size: SZ_D, sign: 1'b0};
        OP_W'('h04): dec = '{kind: K_ST,   size: SZ_W, sign: 1'b0};
        OP_W'('h05): dec = '{kind: K_ST,   size: SZ_B, sign: 1'b0};
        OP_W'('h06): dec = '{kind: K_ST,   size: SZ_H, sign: 1'b0};
        OP_W'('h07): dec = '{kind: K_STD,  size: SZ_D, sign: 1'b0};
        OP_W'('h09): dec = '{kind: K_LD,   size: SZ_B, sign: 1'b1};
        OP_W'('h0A): dec = '{kind: K_LD,   size: SZ_H, sign: 1'b1};
        OP_W'('h0D): dec = '{kind: K_TAS,  size: SZ_B, sign: 1'b0};
        OP_W'('h0F): dec = '{kind: K_SWAP, size: SZ_W, sign: 1'b0};
        default:     dec = '{kind: K_NONE, size: SZ_W, sign: 1'b0};
      endcase
    end
  end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] roff,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  size_e             size,
  output logic [DATA_W-1:0] ea,
  output logic              misalign
);
  logic [DATA_W-1:0] imm_ext;
  logic [2:0]        mask;

  assign imm_ext  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign ea       = base + (use_imm ? imm_ext : roff);
  // size is log2 of bytes: low address bits under the mask must be zero
  assign mask     = 3'((4'd1 << size) - 4'd1);
  assign misalign = |(ea[2:0] & mask);
endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  size_e             size,
  input  logic              sign,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] rdata,
  output logic [BYTES-1:0]  be,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ld_val
);
  localparam int HALVES = BYTES / 2;

  logic [OFF_W-2:0]  hoff;
  logic [DATA_W-1:0] sh_b, sh_h;
  logic [7:0]        bsel;
  logic [15:0]       hsel;

  assign hoff = off[OFF_W-1:1];

  // big-endian lanes: offset k sits in enable bit BYTES-1-k
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam int K = BYTES - 1 - g;
    always_comb begin
      case (size)
        SZ_B:    be[g] = (off == OFF_W'(K));
        SZ_H:    be[g] = (hoff == (OFF_W-1)'(K / 2));
        default: be[g] = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (size)
      SZ_B:    wdata = {BYTES{st_data[7:0]}};
      SZ_H:    wdata = {HALVES{st_data[15:0]}};
      default: wdata = st_data;
    endcase
  end

  assign sh_b = rdata >> {(OFF_W'(BYTES - 1) - off), 3'b000};
  assign sh_h = rdata >> {((OFF_W-1)'(HALVES - 1) - hoff), 4'b0000};
  assign bsel = sh_b[7:0];
  assign hsel = sh_h[15:0];

  always_comb begin
    case (size)
      SZ_B:    ld_val = {{(DATA_W-8){sign & bsel[7]}}, bsel};
      SZ_H:    ld_val = {{(DATA_W-16){sign & hsel[15]}}, hsel};
      default: ld_val = rdata;
    endcase
  end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int OP_W   = 6,
  parameter int IMM_W  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_fmt,
  input  logic [OP_W-1:0]     in_op3,
  input  logic [REG_W-1:0]    in_rd,
  input  logic [DATA_W-1:0]   in_rs1,
  input  logic [DATA_W-1:0]   in_rs2,
  input  logic                in_use_imm,
  input  logic [IMM_W-1:0]    in_simm,
  input  logic [DATA_W-1:0]   in_st_data,
  input  logic [DATA_W-1:0]   in_st_data2,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_lock,
  output logic [DATA_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                wb_valid,
  input  logic                wb_ready,
  output logic [REG_W-1:0]    wb_rd,
  output logic [DATA_W-1:0]   wb_data,
  output logic [DATA_W-1:0]   wb_data2,
  output logic                wb_pair,
  output logic                exc_misalign
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  dec_t              dec_in;
  logic [DATA_W-1:0] ea_in;
  logic              mis_in;

  state_e            state_q;
  kind_e             kind_q;
  size_e             size_q;
  logic              sign_q;
  logic [DATA_W-1:0] ea_q;
  logic [REG_W-1:0]  rd_q;
  logic [DATA_W-1:0] sd1_q, sd2_q, res0_q, res1_q;
  logic              exc_q;

  logic [DATA_W-1:0] base_addr, next_addr, lane_src, lane_wdata, lane_ld;
  logic [BYTES-1:0]  lane_be;
  logic              atomic_q;

  lsu_decode #(.OP_W(OP_W)) u_dec (
    .fmt (in_fmt),
    .op  (in_op3),
    .dec (dec_in)
  );

  lsu_agu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_agu (
    .base     (in_rs1),
    .roff     (in_rs2),
    .use_imm  (in_use_imm),
    .imm      (in_simm),
    .size     (dec_in.size),
    .ea       (ea_in),
    .misalign (mis_in)
  );

  assign lane_src = (kind_q == K_TAS) ? '1 : sd1_q;

  lsu_lane #(.DATA_W(DATA_W)) u_lane (
    .size    (size_q),
    .sign    (sign_q),
    .off     (ea_q[OFF_W-1:0]),
    .st_data (lane_src),
    .rdata   (mem_rdata),
    .be      (lane_be),
    .wdata   (lane_wdata),
    .ld_val  (lane_ld)
  );

  assign atomic_q  = (kind_q == K_TAS) || (kind_q == K_SWAP);
  assign base_addr = {ea_q[DATA_W-1:OFF_W], OFF_W'(0)};
  assign next_addr = base_addr + DATA_W'(BYTES);

  assign in_ready     = (state_q == ST_IDLE);
  assign wb_valid     = (state_q == ST_WB);
  assign wb_rd        = rd_q;
  assign wb_data      = res0_q;
  assign wb_data2     = res1_q;
  assign wb_pair      = (kind_q == K_LDD);
  assign exc_misalign = exc_q;

  // memory request for the current phase
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_lock  = 1'b0;
    mem_addr  = base_addr;
    mem_be    = '0;
    mem_wdata = '0;
    case (state_q)
      ST_ISSUE0: begin
        mem_req  = 1'b1;
        mem_lock = atomic_q;
        case (kind_q)
          K_ST: begin
            mem_we    = 1'b1;
            mem_be    = lane_be;
            mem_wdata = lane_wdata;
          end
          K_STD: begin
            mem_we    = 1'b1;
            mem_be    = '1;
            mem_wdata = sd1_q;
          end
          default: mem_we = 1'b0;
        endcase
      end
      ST_ISSUE1: begin
        mem_req  = 1'b1;
        mem_lock = atomic_q;
        case (kind_q)
          K_LDD: mem_addr = next_addr;
          K_STD: begin
            mem_addr  = next_addr;
            mem_we    = 1'b1;
            mem_be    = '1;
            mem_wdata = sd2_q;
          end
          K_TAS: begin
            mem_we    = 1'b1;
            mem_be    = lane_be;
            mem_wdata = lane_wdata;
          end
          K_SWAP: begin
            mem_we    = 1'b1;
            mem_be    = '1;
            mem_wdata = sd1_q;
          end
          default: mem_req = 1'b0;
        endcase
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_NONE;
      size_q  <= SZ_W;
      sign_q  <= 1'b0;
      ea_q    <= '0;
      rd_q    <= '0;
      sd1_q   <= '0;
      sd2_q   <= '0;
      res0_q  <= '0;
      res1_q  <= '0;
      exc_q   <= 1'b0;
    end else begin
      exc_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid && dec_in.kind != K_NONE) begin
            if (mis_in) begin
              exc_q <= 1'b1;
            end else begin
              kind_q  <= dec_in.kind;
              size_q  <= dec_in.size;
              sign_q  <= dec_in.sign;
              ea_q    <= ea_in;
              rd_q    <= (dec_in.size == SZ_D) ? {in_rd[REG_W-1:1], 1'b0} : in_rd;
              sd1_q   <= in_st_data;
              sd2_q   <= in_st_data2;
              state_q <= ST_ISSUE0;
            end
          end
        end
        ST_ISSUE0: begin
          case (kind_q)
            K_ST:    state_q <= ST_IDLE;
            K_LD:    state_q <= ST_CAPT;
            default: state_q <= ST_ISSUE1;
          endcase
        end
        ST_ISSUE1: begin
          case (kind_q)
            K_LDD: begin
              res0_q  <= mem_rdata;
              state_q <= ST_CAPT;
            end
            K_TAS, K_SWAP: begin
              res0_q  <= lane_ld;
              state_q <= ST_WB;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_CAPT: begin
          if (kind_q == K_LDD) res1_q <= mem_rdata;
          else                 res0_q <= lane_ld;
          state_q <= ST_WB;
        end
        ST_WB: begin
          if (wb_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: a locked sequence never lets a request in
  a_r10_lock_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !in_ready);

  // R10: a locked read is followed at once by a locked write to the same word
  a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && mem_req && !mem_we) |=>
      (mem_lock && mem_req && mem_we && mem_addr == $past(mem_addr)));

  // R3: the exception cycle carries no memory access and no writeback
  a_r3_exception_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    exc_misalign |-> (!mem_req && !wb_valid));

  // R12: a stalled writeback beat holds its contents
  a_r12_writeback_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=>
      (wb_valid && $stable(wb_data) && $stable(wb_data2) && $stable(wb_rd) && $stable(wb_pair)));

  // R11: a consumed writeback returns the unit to idle
  a_r11_idle_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> (in_ready && !wb_valid));

  // R6: every write enables at least one lane
  a_r6_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != '0));

endmodule

// File: tb/mem_access_unit_bench.sv
module mem_access_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_fmt = 2'b11;
  logic [5:0]  in_op3 = '0;
  logic [4:0]  in_rd = '0;
  logic [31:0] in_rs1 = '0, in_rs2 = '0;
  logic        in_use_imm = 1'b0;
  logic [12:0] in_simm = '0;
  logic [31:0] in_st_data = '0, in_st_data2 = '0;
  logic        mem_req, mem_we, mem_lock;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data, wb_data2;
  logic        wb_pair, exc_misalign;

  always #10 clk = ~clk;

  mem_access_unit u_mem_access_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_fmt, .in_op3, .in_rd,
    .in_rs1, .in_rs2, .in_use_imm, .in_simm, .in_st_data, .in_st_data2,
    .mem_req, .mem_we, .mem_lock, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
    .wb_valid, .wb_ready, .wb_rd, .wb_data, .wb_data2, .wb_pair, .exc_misalign
  );

  function automatic logic [7:0] init_byte(input int a);
    return 8'((a * 53 + 135) & 255);
  endfunction

  function automatic logic [31:0] init_word(input int i);
    return {init_byte(4*i), init_byte(4*i+1), init_byte(4*i+2), init_byte(4*i+3)};
  endfunction

  // synchronous memory: reads return on the next cycle
  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
      end
    end
  end

  // independent big-endian reference image
  logic [31:0] ref_mem [64];

  function automatic logic [7:0] rbyte(input logic [31:0] a);
    return ref_mem[a[7:2]][8*(3 - int'(a[1:0])) +: 8];
  endfunction

  task automatic wbyte(input logic [31:0] a, input logic [7:0] v);
    ref_mem[a[7:2]][8*(3 - int'(a[1:0])) +: 8] = v;
  endtask

  function automatic logic [31:0] rword(input logic [31:0] a);
    return {rbyte(a), rbyte(a+1), rbyte(a+2), rbyte(a+3)};
  endfunction

  task automatic wword(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) wbyte(a + 32'(k), v[31-8*k -: 8]);
  endtask

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kinds: 0 ignored, 1 load, 2 pair load, 3 store, 4 atomic, 5 misaligned, 6 pair store
  task automatic model(input logic [5:0] op, input logic [31:0] ea, input logic [31:0] d1,
                       input logic [31:0] d2, output int kind, output logic [31:0] e0,
                       output logic [31:0] e1);
    int sz;
    e0 = '0; e1 = '0;
    case (op)
      6'h01, 6'h05, 6'h09, 6'h0D: sz = 1;
      6'h02, 6'h06, 6'h0A:        sz = 2;
      6'h03, 6'h07:               sz = 8;
      6'h00, 6'h04, 6'h0F:        sz = 4;
      default:                    sz = 0;
    endcase
    if (sz == 0) begin
      kind = 0;
    end else if ((int'(ea[2:0]) % sz) != 0) begin
      kind = 5;
    end else begin
      case (op)
        6'h00: begin kind = 1; e0 = rword(ea); end
        6'h01: begin kind = 1; e0 = {24'h0, rbyte(ea)}; end
        6'h02: begin kind = 1; e0 = {16'h0, rbyte(ea), rbyte(ea+1)}; end
        6'h09: begin kind = 1; e0 = {{24{rbyte(ea)[7]}}, rbyte(ea)}; end
        6'h0A: begin kind = 1; e0 = {{16{rbyte(ea)[7]}}, rbyte(ea), rbyte(ea+1)}; end
        6'h03: begin kind = 2; e0 = rword(ea); e1 = rword(ea+4); end
        6'h04: begin kind = 3; wword(ea, d1); end
        6'h05: begin kind = 3; wbyte(ea, d1[7:0]); end
        6'h06: begin kind = 3; wbyte(ea, d1[15:8]); wbyte(ea+1, d1[7:0]); end
        6'h07: begin kind = 6; wword(ea, d1); wword(ea+4, d2); end
        6'h0D: begin kind = 4; e0 = {24'h0, rbyte(ea)}; wbyte(ea, 8'hFF); end
        default: begin kind = 4; e0 = rword(ea); wword(ea, d1); end
      endcase
    end
  endtask

  // observations, edges counted from the accepting edge
  int          o_wb_n, o_exc_n, o_rdy_n, o_wb_cnt;
  bit          o_wb_steady;
  logic [31:0] o_d0, o_d1;
  logic [4:0]  o_rd;
  logic        o_pair, o_lock1, o_lock2, o_we1, o_we2, o_req1;

  task automatic issue(input logic [1:0] fmt, input logic [5:0] op, input logic [31:0] rs1,
                       input logic [31:0] rs2, input logic ui, input logic [12:0] si,
                       input logic [4:0] rd, input logic [31:0] d1, input logic [31:0] d2);
    @(negedge clk);
    in_fmt = fmt; in_op3 = op; in_rs1 = rs1; in_rs2 = rs2; in_use_imm = ui;
    in_simm = si; in_rd = rd; in_st_data = d1; in_st_data2 = d2; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    o_wb_n = 0; o_exc_n = 0; o_rdy_n = 0; o_wb_cnt = 0; o_wb_steady = 1;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (n == 1) in_valid = 1'b0;
      if (wb_valid) begin
        o_wb_cnt++;
        if (o_wb_n == 0) begin
          o_wb_n = n; o_d0 = wb_data; o_d1 = wb_data2; o_rd = wb_rd; o_pair = wb_pair;
        end else if (wb_data != o_d0 || wb_data2 != o_d1 || wb_rd != o_rd) begin
          o_wb_steady = 0;
        end
      end
      if (exc_misalign && o_exc_n == 0) o_exc_n = n;
      if (in_ready && o_rdy_n == 0) o_rdy_n = n;
      if (n == 1) begin o_lock1 = mem_lock; o_we1 = mem_we; o_req1 = mem_req; end
      if (n == 2) begin o_lock2 = mem_lock; o_we2 = mem_we; end
    end
  endtask

  task automatic check_image(input string tag);
    int bad = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, tag, 64'(bad), 64'd0);
  endtask

  // {op3[6], rs1[8], use_imm, offset[13], rd[5]}
  localparam int NV = 20;
  localparam logic [32:0] VEC [NV] = '{
    {6'h00, 8'h20, 1'b1, 13'h0004, 5'd3},   // word load
    {6'h01, 8'h10, 1'b0, 13'h0001, 5'd5},   // unsigned byte, lane 1, register offset
    {6'h01, 8'h13, 1'b1, 13'h0000, 5'd8},   // unsigned byte, lane 3
    {6'h09, 8'h08, 1'b1, 13'h1FFD, 5'd6},   // signed byte, negative immediate
    {6'h0A, 8'h02, 1'b0, 13'h0000, 5'd4},   // signed halfword, low half
    {6'h02, 8'h28, 1'b1, 13'h0002, 5'd9},   // unsigned halfword
    {6'h03, 8'h30, 1'b1, 13'h0008, 5'd11},  // pair load, odd rd
    {6'h04, 8'h50, 1'b1, 13'h0004, 5'd1},   // word store
    {6'h05, 8'h60, 1'b1, 13'h0002, 5'd2},   // byte store
    {6'h06, 8'h70, 1'b0, 13'h0002, 5'd2},   // halfword store
    {6'h07, 8'h80, 1'b1, 13'h0000, 5'd12},  // pair store
    {6'h0D, 8'h90, 1'b1, 13'h0001, 5'd13},  // test-and-set
    {6'h0F, 8'hA0, 1'b1, 13'h0004, 5'd7},   // swap
    {6'h02, 8'h20, 1'b1, 13'h0001, 5'd3},   // misaligned halfword
    {6'h00, 8'h20, 1'b1, 13'h0002, 5'd3},   // misaligned word
    {6'h03, 8'h40, 1'b1, 13'h0004, 5'd2},   // misaligned pair
    {6'h04, 8'h50, 1'b1, 13'h0003, 5'd1},   // misaligned store
    {6'h08, 8'h10, 1'b1, 13'h0000, 5'd1},   // unlisted code
    {6'h01, 8'h90, 1'b1, 13'h0001, 5'd14},  // read back test-and-set byte
    {6'h00, 8'h50, 1'b1, 13'h0004, 5'd15}   // read back word store
  };

  function automatic string req_of(input logic [5:0] op);
    case (op)
      6'h09, 6'h0A: return "R5";
      6'h03:        return "R7";
      6'h0D:        return "R8";
      6'h0F:        return "R9";
      default:      return "R4";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = init_word(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk(in_ready === 1'b1, "R13 in_ready", 64'(in_ready), 64'd1);
    chk({wb_valid, mem_req, mem_lock, exc_misalign} === 4'b0, "R13 outputs idle",
        64'({wb_valid, mem_req, mem_lock, exc_misalign}), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [5:0]  op;
      logic [31:0] rs1, rs2, ea, d1, d2, e0, e1;
      logic        ui;
      logic [12:0] off;
      logic [4:0]  rd;
      int          kind;
      {op, rs1[7:0], ui, off, rd} = VEC[v];
      rs1[31:8] = '0;
      // R1: the operand not selected carries junk
      rs2 = ui ? 32'hDEAD_0000 : {19'h0, off};
      ea  = rs1 + (ui ? {{19{off[12]}}, off} : rs2);
      d1  = 32'hC0DE_0000 + 32'(v * 4371);
      d2  = 32'h5EED_0000 + 32'(v * 977);
      model(op, ea, d1, d2, kind, e0, e1);
      issue(2'b11, op, rs1, rs2, ui, off, rd, d1, d2);
      case (kind)
        1, 2, 4: begin
          chk(o_wb_n == (kind == 2 ? 4 : 3), "R11 writeback latency", 64'(o_wb_n), 64'(kind == 2 ? 4 : 3));
          chk(o_d0 === e0, {"R1 ", req_of(op), " data"}, 64'(o_d0), 64'(e0));
          chk(o_rd === (kind == 2 ? {rd[4:1], 1'b0} : rd), "R7 destination", 64'(o_rd), 64'(rd));
          chk(o_pair === (kind == 2), "R7 pair flag", 64'(o_pair), 64'(kind == 2));
          if (kind == 2) chk(o_d1 === e1, "R7 second word", 64'(o_d1), 64'(e1));
          if (kind == 4) begin
            chk({o_lock1, o_we1, o_lock2, o_we2} === 4'b1011, "R10 locked read then write",
                64'({o_lock1, o_we1, o_lock2, o_we2}), 64'hB);
            chk(o_rdy_n == 4, "R10 no request during lock", 64'(o_rdy_n), 64'd4);
          end
        end
        3, 6: begin
          chk(o_rdy_n == (kind == 6 ? 3 : 2), "R11 store completion", 64'(o_rdy_n), 64'(kind == 6 ? 3 : 2));
          chk(o_wb_n == 0, "R6 store gives no writeback", 64'(o_wb_n), 64'd0);
        end
        5: begin
          chk(o_exc_n == 1, "R3 exception timing", 64'(o_exc_n), 64'd1);
          chk(o_wb_n == 0 && o_req1 == 1'b0, "R3 no access on misalign", 64'(o_wb_n), 64'd0);
        end
        default: begin
          chk(o_wb_n == 0 && o_exc_n == 0 && o_rdy_n == 1, "R2 unlisted code ignored",
              64'(o_rdy_n), 64'd1);
        end
      endcase
      if (kind != 5) chk(o_exc_n == 0, "R3 no spurious exception", 64'(o_exc_n), 64'd0);
      check_image("R6 memory image");
    end

    // R2: format other than 2'b11 is ignored even with a store code
    issue(2'b10, 6'h04, 32'h10, 32'h0, 1'b1, 13'h0, 5'd1, 32'hFFFF_FFFF, 32'h0);
    chk(o_wb_n == 0 && o_exc_n == 0 && o_rdy_n == 1, "R2 wrong format ignored", 64'(o_rdy_n), 64'd1);
    check_image("R2 memory untouched");

    // R12: writeback back-pressure
    wb_ready = 1'b0;
    issue(2'b11, 6'h00, 32'h40, 32'h0, 1'b1, 13'h0, 5'd10, 32'h0, 32'h0);
    chk(o_wb_cnt == 4 && o_wb_steady, "R12 beat held while stalled", 64'(o_wb_cnt), 64'd4);
    chk(o_rdy_n == 0, "R12 no request while stalled", 64'(o_rdy_n), 64'd0);
    chk(o_d0 === rword(32'h40), "R12 held data", 64'(o_d0), 64'(rword(32'h40)));
    wb_ready = 1'b1;
    @(negedge clk);
    chk(!wb_valid && in_ready, "R12 released", 64'({wb_valid, in_ready}), 64'b01);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule